// File: doc/BRIEF.md
# IO Address Translation Table Walker

This block turns 32-bit IO virtual addresses from DMA masters into physical addresses. Each lookup reads one entry from a single-level page table in memory. Software sets the block up through a small word-indexed register file. That file holds a control word, the table base, two flush strobes and a fixed module identifier. The control word carries an enable bit and a 3-bit range code. The range code sets how large the translation window is. The window always ends at the top of the 32-bit space, and its size is a power of two.

A DMA master offers an address and a read/write flag with a valid/ready handshake. The block works one request at a time, in this order:

- It checks the enable bit and that the address lies inside the window.
- It computes where the page-table entry sits.
- It issues one 32-bit read on its memory port.
- It checks the returned entry.
- It reports either a physical address, with the entry's cacheable flag, or a fault.

Pages are 4 KB. A request that fails the enable or window check faults without touching memory.

Top module: `io_xlate_walker`

## Requirements
- R1: The window start is 0xFF000000 shifted left by the range code held in control bits [4:2]. The codes 0..7 give 0xFF000000 down to 0x80000000. The window reaches up to 0xFFFFFFFF. A request below the window start faults.
- R2: Control bit 0 is the translation enable, and bits [4:2] hold the range code. Both are written and read back. Bits [31:28] read the implementation code 0x4 and bits [27:24] read the version code 0x1, and writes never change them. All other control bits read 0. After reset the control word reads 0x41000000.
- R3: The register at word index 0 is control and the one at index 1 is the table base, which is fully writable and resets to 0. Indices 5 and 6 are the two flush strobes. They read 0, and a write to either changes no other register and no translation.
- R4: Word index 2048 is the module identifier, which reads 0x00000008. Undecoded indices read 0.
- R5: When enable is clear or the address is outside the window, the result comes back as a fault with address 0. No memory read is issued, and the result is valid in the cycle after the request is accepted.
- R6: The entry is read at (table base << 4) + ((address − window start) >> 12) × 4, truncated to 32 bits. The memory request address stays stable while it waits for memory ready.
- R7: For a good entry, the physical address is {0, entry[26:8], address[11:0]}. The cacheable output copies entry bit 7.
- R8: An entry whose bit 1 (valid) is clear faults. A write request to an entry whose bit 2 (writeable) is clear faults. A read request to that same entry succeeds.
- R9: Only one walk runs at a time. Request ready is high only while idle and drops in the cycle after a request is accepted.
- R10: The result is valid for exactly one cycle: the cycle after the memory response is taken. Request ready returns in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_idx | input | 12 | Register word index (byte offset >> 2) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx (combinational) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_addr | input | 32 | IO virtual address |
| req_write | input | 1 | Request is a write access |
| mem_req_valid | output | 1 | Page-table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the page-table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Page-table entry returned |
| res_valid | output | 1 | Result valid, one-cycle pulse |
| res_fault | output | 1 | Translation fault |
| res_paddr | output | 32 | Physical address (0 on fault) |
| res_cacheable | output | 1 | Entry marked cacheable |

## Verification
A request that faults on enable or window gives its result one clock edge after acceptance. The bench samples that result at the following falling edge. A walking request shows its memory read one edge after acceptance. The read is taken at the next edge. The result appears one edge after the response is driven. The bench drives each input at a falling edge and samples each output at the next falling edge that the register count gives. In this way every check lands in the only cycle where the pulse is defined. Register reads are combinational, so they are sampled a short delay after the index is set.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int RANGE_W    = 3;

    localparam int PTE_VALID_BIT = 1;
    localparam int PTE_WRITE_BIT = 2;
    localparam int PTE_CACHE_BIT = 7;
    localparam int PTE_PPN_LSB   = 8;
    localparam int PTE_PPN_MSB   = 26;
    localparam int PPN_W         = PTE_PPN_MSB - PTE_PPN_LSB + 1;

    localparam logic [ADDR_W-1:0] WIN_TOP_16M = 32'hFF00_0000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic              fault;
        logic              cacheable;
        logic [ADDR_W-1:0] paddr;
    } xlate_res_t;

    function automatic logic [ADDR_W-1:0] window_start(input logic [RANGE_W-1:0] code);
        return WIN_TOP_16M << code;
    endfunction

    function automatic xlate_res_t judge_pte(input logic [31:0] pte,
                                             input logic        is_write,
                                             input logic [PAGE_SHIFT-1:0] offs);
        xlate_res_t r;
        r = '0;
        if (!pte[PTE_VALID_BIT] || (is_write && !pte[PTE_WRITE_BIT])) begin
            r.fault = 1'b1;
        end else begin
            r.cacheable = pte[PTE_CACHE_BIT];
            r.paddr     = {{(ADDR_W-PPN_W-PAGE_SHIFT){1'b0}},
                           pte[PTE_PPN_MSB:PTE_PPN_LSB], offs};
        end
        return r;
    endfunction

endpackage

// File: rtl/xw_regfile.sv
module xw_regfile
    import xw_pkg::*;
#(
    parameter int          IDX_W      = 12,
    parameter int          CTRL_IDX   = 0,
    parameter int          BASE_IDX   = 1,
    parameter int          TFLUSH_IDX = 5,
    parameter int          PFLUSH_IDX = 6,
    parameter int          MID_IDX    = 2048,
    parameter logic [3:0]  IMPL_CODE  = 4'h4,
    parameter logic [3:0]  VERS_CODE  = 4'h1,
    parameter logic [3:0]  MID_VALUE  = 4'h8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wen,
    input  logic [IDX_W-1:0]    idx,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    output logic                xlate_en,
    output logic [RANGE_W-1:0]  range_code,
    output logic [31:0]         table_base
);
    localparam logic [IDX_W-1:0] I_CTRL = IDX_W'(CTRL_IDX);
    localparam logic [IDX_W-1:0] I_BASE = IDX_W'(BASE_IDX);
    localparam logic [IDX_W-1:0] I_TFL  = IDX_W'(TFLUSH_IDX);
    localparam logic [IDX_W-1:0] I_PFL  = IDX_W'(PFLUSH_IDX);
    localparam logic [IDX_W-1:0] I_MID  = IDX_W'(MID_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            xlate_en   <= 1'b0;
            range_code <= '0;
            table_base <= '0;
        end else if (wen) begin
            if (idx == I_CTRL) begin
                xlate_en   <= wdata[0];
                range_code <= wdata[4:2];
            end else if (idx == I_BASE) begin
                table_base <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (idx == I_CTRL) begin
            rdata = {IMPL_CODE, VERS_CODE, 19'b0, range_code, 1'b0, xlate_en};
        end else if (idx == I_BASE) begin
            rdata = table_base;
        end else if (idx == I_MID) begin
            rdata = {28'b0, MID_VALUE};
        end
    end

    assert_flush_no_effect_R3: assert property (@(posedge clk) disable iff (rst)
        (wen && (idx == I_TFL || idx == I_PFL)) |=>
            ($stable(table_base) && $stable(range_code) && $stable(xlate_en)));

endmodule

// File: rtl/xw_window.sv
module xw_window
    import xw_pkg::*;
(
    input  logic [RANGE_W-1:0]  range_code,
    input  logic [31:0]         table_base,
    input  logic [ADDR_W-1:0]   vaddr,
    output logic                in_window,
    output logic [ADDR_W-1:0]   entry_addr
);
    logic [ADDR_W-1:0] start;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] page_idx;

    always_comb begin
        start      = window_start(range_code);
        in_window  = (vaddr >= start);
        offset     = vaddr - start;
        page_idx   = offset >> PAGE_SHIFT;
        entry_addr = (table_base << 4) + (page_idx << 2);
    end
endmodule

// File: rtl/xw_walk_fsm.sv
module xw_walk_fsm
    import xw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    input  logic               xlate_en,
    input  logic               in_window,
    input  logic [ADDR_W-1:0]  entry_addr,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [31:0]        mem_rsp_data,
    output logic               res_valid,
    output xlate_res_t         res
);
    walk_st_e              st;
    logic [ADDR_W-1:0]     maddr_q;
    logic [PAGE_SHIFT-1:0] offs_q;
    logic                  wr_q;
    xlate_res_t            res_q;
    logic                  accept;

    assign accept        = req_valid && (st == ST_IDLE);
    assign req_ready     = (st == ST_IDLE);
    assign mem_req_valid = (st == ST_FETCH);
    assign mem_req_addr  = maddr_q;
    assign res_valid     = (st == ST_DONE);
    assign res           = res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            maddr_q <= '0;
            offs_q  <= '0;
            wr_q    <= 1'b0;
            res_q   <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (accept) begin
                    offs_q <= req_addr[PAGE_SHIFT-1:0];
                    wr_q   <= req_write;
                    if (!xlate_en || !in_window) begin
                        res_q <= '{fault: 1'b1, cacheable: 1'b0, paddr: '0};
                        st    <= ST_DONE;
                    end else begin
                        maddr_q <= entry_addr;
                        st      <= ST_FETCH;
                    end
                end
                ST_FETCH: if (mem_req_ready) st <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    res_q <= judge_pte(mem_rsp_data, wr_q, offs_q);
                    st    <= ST_DONE;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_fault_skips_fetch_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !xlate_en) |=> (!mem_req_valid && res_valid && res.fault));

    assert_req_addr_held_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_one_walk_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_to_result_R10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && mem_rsp_valid) |=> (res_valid && !req_ready));

    assert_result_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> (!res_valid && req_ready));

endmodule

// File: rtl/io_xlate_walker.sv
module io_xlate_walker
    import xw_pkg::*;
#(
    parameter int IDX_W   = 12,
    parameter int MID_IDX = 2048
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wen,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [31:0]        req_addr,
    input  logic               req_write,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [31:0]        mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [31:0]        mem_rsp_data,
    output logic               res_valid,
    output logic               res_fault,
    output logic [31:0]        res_paddr,
    output logic               res_cacheable
);
    logic               xlate_en;
    logic [RANGE_W-1:0] range_code;
    logic [31:0]        table_base;
    logic               in_window;
    logic [ADDR_W-1:0]  entry_addr;
    xlate_res_t         res;

    xw_regfile #(.IDX_W(IDX_W), .MID_IDX(MID_IDX)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wen        (reg_wen),
        .idx        (reg_idx),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .xlate_en   (xlate_en),
        .range_code (range_code),
        .table_base (table_base)
    );

    xw_window u_win (
        .range_code (range_code),
        .table_base (table_base),
        .vaddr      (req_addr),
        .in_window  (in_window),
        .entry_addr (entry_addr)
    );

    xw_walk_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_write     (req_write),
        .xlate_en      (xlate_en),
        .in_window     (in_window),
        .entry_addr    (entry_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .res_valid     (res_valid),
        .res           (res)
    );

    assign res_fault     = res.fault;
    assign res_paddr     = res.paddr;
    assign res_cacheable = res.cacheable;

endmodule

// File: tb/tb_io_xlate_walker.sv
module tb_io_xlate_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wen = 1'b0;
    logic [11:0] reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_fault;
    logic [31:0] res_paddr;
    logic        res_cacheable;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    io_xlate_walker dut (
        .clk(clk), .rst(rst),
        .reg_wen(reg_wen), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_fault(res_fault), .res_paddr(res_paddr),
        .res_cacheable(res_cacheable)
    );

    typedef struct packed {
        logic [2:0]  code;
        logic        en;
        logic [31:0] base;
        logic [31:0] addr;
        logic        wr;
        logic [31:0] pte;
        logic        exp_mem;
        logic [31:0] exp_maddr;
        logic        exp_fault;
        logic [31:0] exp_pa;
        logic        exp_cache;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b1, 32'h0010_0000, 32'hFF00_3ABC, 1'b0, 32'h0123_4582, 1'b1, 32'h0100_000C, 1'b0, 32'h1234_5ABC, 1'b1},
        '{3'd7, 1'b1, 32'h0000_1000, 32'h8000_0010, 1'b1, 32'h07FF_FF06, 1'b1, 32'h0001_0000, 1'b0, 32'h7FFF_F010, 1'b0},
        '{3'd7, 1'b1, 32'h0000_1000, 32'hFFFF_F123, 1'b0, 32'h0000_0102, 1'b1, 32'h0020_FFFC, 1'b0, 32'h0000_1123, 1'b0},
        '{3'd3, 1'b1, 32'h0000_1000, 32'hF7FF_FFFF, 1'b0, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b0},
        '{3'd3, 1'b1, 32'h0000_1000, 32'hF800_5000, 1'b1, 32'h0000_0A02, 1'b1, 32'h0001_0014, 1'b1, 32'h0000_0000, 1'b0},
        '{3'd3, 1'b1, 32'h0000_1000, 32'hF800_5000, 1'b0, 32'h0000_0A02, 1'b1, 32'h0001_0014, 1'b0, 32'h0000_A000, 1'b0},
        '{3'd1, 1'b1, 32'h0000_1000, 32'hFE00_2004, 1'b0, 32'h0000_4400, 1'b1, 32'h0001_0008, 1'b1, 32'h0000_0000, 1'b0},
        '{3'd0, 1'b0, 32'h0000_1000, 32'hFF00_0000, 1'b0, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b0},
        '{3'd0, 1'b1, 32'h0000_1000, 32'hFEFF_FFFF, 1'b0, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] idx, output logic [31:0] d);
        reg_idx = idx;
        #1;
        d = reg_rdata;
    endtask

    task automatic run_vec(input vec_t v, input int n);
        @(negedge clk);
        req_valid = 1'b1; req_addr = v.addr; req_write = v.wr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check($sformatf("R9 ready low after accept v%0d", n), 32'(req_ready), 32'd0);
        if (v.exp_mem) begin
            check($sformatf("R6 fetch issued v%0d", n), 32'(mem_req_valid), 32'd1);
            check($sformatf("R6 entry address v%0d", n), mem_req_addr, v.exp_maddr);
            @(negedge clk);
            mem_rsp_valid = 1'b1; mem_rsp_data = v.pte;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            check($sformatf("R10 result due v%0d", n), 32'(res_valid), 32'd1);
            check($sformatf("R8 fault flag v%0d", n), 32'(res_fault), 32'(v.exp_fault));
            check($sformatf("R7 physical address v%0d", n), res_paddr, v.exp_pa);
            check($sformatf("R7 cacheable v%0d", n), 32'(res_cacheable), 32'(v.exp_cache));
        end else begin
            check($sformatf("R5 no fetch v%0d", n), 32'(mem_req_valid), 32'd0);
            check($sformatf("R5 result next cycle v%0d", n), 32'(res_valid), 32'd1);
            check($sformatf("R1/R5 fault v%0d", n), 32'(res_fault), 32'd1);
            check($sformatf("R5 zero address v%0d", n), res_paddr, 32'd0);
        end
        @(negedge clk);
        check($sformatf("R10 pulse ends v%0d", n), 32'(res_valid), 32'd0);
        check($sformatf("R10 ready back v%0d", n), 32'(req_ready), 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        reg_read(12'd0, d);    check("R2 control after reset", d, 32'h4100_0000);
        reg_read(12'd1, d);    check("R3 base after reset", d, 32'h0);
        reg_read(12'd2048, d); check("R4 module id", d, 32'h0000_0008);
        reg_read(12'd3, d);    check("R4 undecoded index", d, 32'h0);
        check("R9 ready after reset", 32'(req_ready), 32'd1);
        check("R10 no result after reset", 32'(res_valid), 32'd0);

        reg_write(12'd0, 32'hFFFF_FFFF);
        reg_read(12'd0, d);    check("R2 read-only codes kept", d, 32'h4100_001D);
        for (int c = 0; c < 8; c++) begin
            reg_write(12'd0, 32'(c) << 2);
            reg_read(12'd0, d);
            check($sformatf("R1 range code %0d readback", c), d, 32'h4100_0000 | (32'(c) << 2));
        end

        reg_write(12'd1, 32'h0000_1000);
        reg_write(12'd0, 32'h0000_000D);
        reg_write(12'd5, 32'hFFFF_FFFF);
        reg_write(12'd6, 32'h1234_5678);
        reg_read(12'd5, d);    check("R3 tlb flush reads zero", d, 32'h0);
        reg_read(12'd6, d);    check("R3 page flush reads zero", d, 32'h0);
        reg_read(12'd0, d);    check("R3 control unchanged by flush", d, 32'h4100_000D);
        reg_read(12'd1, d);    check("R3 base unchanged by flush", d, 32'h0000_1000);
        run_vec(VECS[5], 100);

        for (int i = 0; i < NV; i++) begin
            reg_write(12'd1, VECS[i].base);
            reg_write(12'd0, {27'b0, VECS[i].code, 1'b0, VECS[i].en});
            run_vec(VECS[i], i);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule